// File: doc/BRIEF.md
# Edge/Level Selectable Interrupt Controller

This block gathers up to 32 interrupt request lines, one per device or DMA engine, into a single latched CPU interrupt. It keeps the live state of every line, records events, and holds the CPU interrupt high while any enabled event is pending. A 32-bit register port gives access to the events, enables, live line states and an acknowledge word. A fixed identification word and a feature word are also on this port. All data on the port is byte-reversed relative to the register word.

The top bit of the enable word selects the capture mode. When it is clear, an event bit follows its line's rising edges: a rise sets it and a fall clears it. When it is set, every change of the line sets the event bit, and the acknowledge word gains a clear-everything command. Each line is assigned by wiring. DMA engines use lines 0 to 9, devices use lines 12 to 28, and two devices share line 22 through an OR outside the block.

Top module: `sic_top`

## Requirements
- R1: After reset the event, enable and feature words read 0, `cpu_irq` is 0 and `mon_sense_en` is 1.
- R2: Bus data is the register word with its four bytes reversed: bus byte 0 carries register bits 31:24. Register addresses are word indices: 0 events (read-only), 1 enable, 2 acknowledge (write-only, reads 0), 3 line state, 4 identification, 5 feature.
- R3: The line-state word mirrors the synchronised source lines, and writes to it have no effect.
- R4: With enable bit 31 clear, a 0-to-1 change of a line sets its event bit and a 1-to-0 change clears it.
- R5: With enable bit 31 set, any change of a line sets its event bit.
- R6: Writing the acknowledge word clears each event bit written as 1, except event bit 31.
- R7: With enable bit 31 set, an acknowledge write with bit 31 set clears every event bit, including bit 31.
- R8: `cpu_irq` rises on the clock edge at which (events & enable) becomes nonzero, including the edge of an enable write.
- R9: Once high, `cpu_irq` stays high until an acknowledge write or an event update leaves (events & enable) at zero; an enable write alone does not release it.
- R10: The identification word reads as 0xFFFFBFFF, which is all ones except bit 14.
- R11: The feature word is read/write. `mon_sense_en` is the inverse of feature bit 0, updated on the edge of the write.
- R12: Reads at word addresses 6 and 7 return zero.
- R13: A source line change reaches the line-state word, the event word and `cpu_irq` on the third rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Asynchronous interrupt source lines |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data (byte-reversed) |
| bus_rdata | output | 32 | Read data (byte-reversed), registered |
| cpu_irq | output | 1 | Latched CPU interrupt request |
| mon_sense_en | output | 1 | Monitor sense enable (inverse of feature bit 0) |

## Verification
Register writes take effect on the edge that samples the strobe, and read data appears one edge after the read strobe. The bench drives on falling edges and samples on the next falling edge. A source line change needs three rising edges: two synchroniser stages and then the event/level/interrupt registers. The bench checks that `cpu_irq` is still low after two edges and high after the third. Every other line change is given three full cycles before anything is read.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int DW = 32;
  localparam int AW = 3;
  localparam int MODE_BIT = DW - 1;

  localparam logic [AW-1:0] ADR_EVT  = 3'd0;
  localparam logic [AW-1:0] ADR_MASK = 3'd1;
  localparam logic [AW-1:0] ADR_ACK  = 3'd2;
  localparam logic [AW-1:0] ADR_LVL  = 3'd3;
  localparam logic [AW-1:0] ADR_ID   = 3'd4;
  localparam logic [AW-1:0] ADR_FEAT = 3'd5;

  localparam logic [DW-1:0] ID_WORD = ~(32'h1 << 14);

  function automatic logic [DW-1:0] bswap(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    for (int b = 0; b < DW / 8; b++) begin
      r[b*8 +: 8] = v[(DW/8 - 1 - b)*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/sic_sync.sv
module sic_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sic_event_core.sv
module sic_event_core
  import sic_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] line_i,
  input  logic [DW-1:0] mask_q_i,
  input  logic [DW-1:0] mask_d_i,
  input  logic          ack_wr_i,
  input  logic [DW-1:0] ack_bits_i,
  input  logic          ack_all_i,
  output logic [DW-1:0] evt_o,
  output logic [DW-1:0] lvl_o,
  output logic          irq_o
);
  logic [DW-1:0] evt_q, lvl_q, evt_d, chg, kept;
  logic          irq_q, irq_d, pend_d, release_w;
  logic          any_mode;

  assign any_mode = mask_q_i[MODE_BIT];
  assign chg      = line_i ^ lvl_q;

  always_comb begin
    kept = evt_q;
    if (ack_wr_i) begin
      if (ack_all_i) kept = '0;
      else           kept = evt_q & ~{1'b0, ack_bits_i[DW-2:0]};
    end
    for (int i = 0; i < DW; i++) begin
      evt_d[i] = kept[i];
      if (chg[i]) evt_d[i] = any_mode ? 1'b1 : line_i[i];
    end
  end

  assign pend_d    = |(evt_d & mask_d_i);
  assign release_w = ack_wr_i | (|chg);
  assign irq_d     = pend_d | (irq_q & ~release_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
      lvl_q <= '0;
      irq_q <= 1'b0;
    end else begin
      evt_q <= evt_d;
      lvl_q <= line_i;
      irq_q <= irq_d;
    end
  end

  assign evt_o = evt_q;
  assign lvl_o = lvl_q;
  assign irq_o = irq_q;

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> ((evt_q & mask_q_i) != '0)); // R8
  AST_IRQ_RELEASE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_q) |-> ((evt_q & mask_q_i) == '0)); // R9
  AST_ACK_KEEPS_TOP: assert property (@(posedge clk) disable iff (rst)
    (ack_wr_i && !ack_all_i && !chg[MODE_BIT]) |=> (evt_q[MODE_BIT] == $past(evt_q[MODE_BIT]))); // R6
  AST_ACK_ALL_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (ack_wr_i && ack_all_i && chg == '0) |=> (evt_q == '0)); // R7
endmodule

// File: rtl/sic_regs.sv
module sic_regs
  import sic_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] evt_i,
  input  logic [DW-1:0] lvl_i,
  output logic [DW-1:0] mask_q_o,
  output logic [DW-1:0] mask_d_o,
  output logic          ack_wr_o,
  output logic [DW-1:0] ack_bits_o,
  output logic          ack_all_o,
  output logic [DW-1:0] rdata_o,
  output logic          mon_o
);
  logic [DW-1:0] mask_q, feat_q, feat_d, wword, rword, rdata_q;
  logic          mon_q;

  assign wword = bswap(wdata_i);

  always_comb begin
    mask_d_o = mask_q;
    feat_d   = feat_q;
    if (wr_i && addr_i == ADR_MASK) mask_d_o = wword;
    if (wr_i && addr_i == ADR_FEAT) feat_d   = wword;
  end

  assign ack_wr_o   = wr_i && (addr_i == ADR_ACK);
  assign ack_bits_o = wword;
  assign ack_all_o  = ack_wr_o && mask_q[MODE_BIT] && wword[MODE_BIT];

  always_comb begin
    unique case (addr_i)
      ADR_EVT:  rword = evt_i;
      ADR_MASK: rword = mask_q;
      ADR_LVL:  rword = lvl_i;
      ADR_ID:   rword = ID_WORD;
      ADR_FEAT: rword = feat_q;
      default:  rword = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      feat_q  <= '0;
      mon_q   <= 1'b1;
      rdata_q <= '0;
    end else begin
      mask_q <= mask_d_o;
      feat_q <= feat_d;
      mon_q  <= ~feat_d[0];
      if (rd_i) rdata_q <= bswap(rword);
    end
  end

  assign mask_q_o = mask_q;
  assign rdata_o  = rdata_q;
  assign mon_o    = mon_q;

  AST_ID_FIXED: assert property (@(posedge clk) disable iff (rst)
    (rd_i && addr_i == ADR_ID) |=> (rdata_o == 32'hFFBFFFFF)); // R10
  AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_i && addr_i > ADR_FEAT) |=> (rdata_o == '0)); // R12
  AST_MON_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == ADR_FEAT) |=> (mon_o == ~bswap($past(wdata_i))[0])); // R11
endmodule

// File: rtl/sic_top.sv
module sic_top
  import sic_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] src_i,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          cpu_irq,
  output logic          mon_sense_en
);
  logic [DW-1:0] line_s, mask_q, mask_d, ack_bits, evt, lvl;
  logic          ack_wr, ack_all;

  sic_sync #(.WIDTH(DW), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d_i(src_i), .q_o(line_s)
  );

  sic_regs regs_i (
    .clk(clk), .rst(rst), .rd_i(bus_rd), .wr_i(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .evt_i(evt), .lvl_i(lvl), .mask_q_o(mask_q),
    .mask_d_o(mask_d), .ack_wr_o(ack_wr), .ack_bits_o(ack_bits),
    .ack_all_o(ack_all), .rdata_o(bus_rdata), .mon_o(mon_sense_en)
  );

  sic_event_core core_i (
    .clk(clk), .rst(rst), .line_i(line_s), .mask_q_i(mask_q), .mask_d_i(mask_d),
    .ack_wr_i(ack_wr), .ack_bits_i(ack_bits), .ack_all_i(ack_all),
    .evt_o(evt), .lvl_o(lvl), .irq_o(cpu_irq)
  );

  AST_LVL_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADR_LVL) |=> (lvl == $past(line_s))); // R3
endmodule

// File: tb/sic_top_tb_top.sv
module sic_top_tb_top;
  import sic_pkg::*;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] src_i = '0;
  logic          bus_rd = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          cpu_irq, mon_sense_en;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sic_top dut_i (
    .clk(clk), .rst(rst), .src_i(src_i), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_irq(cpu_irq), .mon_sense_en(mon_sense_en)
  );

  function automatic logic [31:0] sw(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] word);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = sw(word);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] word);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    word = sw(bus_rdata);
  endtask

  task automatic drive(input logic [31:0] v);
    @(negedge clk);
    src_i = v;
    repeat (3) @(negedge clk);
  endtask

  // {write, addr, word, expected}
  localparam int NV = 9;
  localparam logic [67:0] VEC [NV] = '{
    {1'b1, 3'd5, 32'h00000001, 32'h0},
    {1'b0, 3'd5, 32'h0,        32'h00000001},
    {1'b0, 3'd4, 32'h0,        32'hFFFFBFFF},
    {1'b0, 3'd7, 32'h0,        32'h0},
    {1'b0, 3'd6, 32'h0,        32'h0},
    {1'b0, 3'd2, 32'h0,        32'h0},
    {1'b1, 3'd1, 32'h12345678, 32'h0},
    {1'b0, 3'd1, 32'h0,        32'h12345678},
    {1'b1, 3'd1, 32'h0,        32'h0}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, r); check("R1 events", r, 32'h0);
    rd(3'd1, r); check("R1 mask", r, 32'h0);
    rd(3'd5, r); check("R1 feature", r, 32'h0);
    check("R1 irq", {31'h0, cpu_irq}, 32'h0);
    check("R1 mon_sense", {31'h0, mon_sense_en}, 32'h1);

    // table walk: R2 R10 R11 R12
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][67]) begin
        wr(VEC[i][66:64], VEC[i][63:32]);
        if (VEC[i][66:64] == 3'd5)
          check("R11 mon_sense after write", {31'h0, mon_sense_en}, {31'h0, ~VEC[i][32]});
      end else begin
        rd(VEC[i][66:64], r);
        check("R2/R10/R11/R12 table read", r, VEC[i][31:0]);
      end
    end
    wr(3'd5, 32'h0);
    check("R11 mon_sense restored", {31'h0, mon_sense_en}, 32'h1);

    // R2 raw bus byte order
    wr(3'd1, 32'h00000004);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 3'd1;
    @(negedge clk); bus_rd = 1'b0;
    check("R2 raw bus bytes", bus_rdata, 32'h04000000);

    // R13 latency, R4 rising edge, R8
    @(negedge clk); src_i = 32'h4;
    @(negedge clk); @(negedge clk);
    check("R13 irq not yet after two edges", {31'h0, cpu_irq}, 32'h0);
    @(negedge clk);
    check("R13 R8 irq on third edge", {31'h0, cpu_irq}, 32'h1);
    rd(3'd0, r); check("R4 rise sets event", r, 32'h4);
    rd(3'd3, r); check("R3 level mirrors", r, 32'h4);
    wr(3'd3, 32'h0);
    rd(3'd3, r); check("R3 level write ignored", r, 32'h4);

    // R4 falling clears, irq released by event update
    drive(32'h0);
    rd(3'd0, r); check("R4 fall clears event", r, 32'h0);
    check("R9 irq released by event update", {31'h0, cpu_irq}, 32'h0);

    // R9 mask write does not release; ack does
    drive(32'h4);
    check("R8 irq again", {31'h0, cpu_irq}, 32'h1);
    wr(3'd1, 32'h0);
    check("R9 irq held after mask cleared", {31'h0, cpu_irq}, 32'h1);
    wr(3'd2, 32'h4);
    check("R9 irq released by ack", {31'h0, cpu_irq}, 32'h0);
    rd(3'd0, r); check("R6 ack clears bit", r, 32'h0);

    // R5 every-transition mode
    wr(3'd1, 32'h80000008);
    drive(32'h0000000C);
    rd(3'd0, r); check("R5 rise sets in mode", r, 32'h8);
    wr(3'd2, 32'h8);
    check("R9 ack releases in mode", {31'h0, cpu_irq}, 32'h0);
    drive(32'h00000004);
    rd(3'd0, r); check("R5 fall sets in mode", r, 32'h8);
    check("R8 irq in mode", {31'h0, cpu_irq}, 32'h1);
    wr(3'd2, 32'h80000000);
    rd(3'd0, r); check("R7 clear-all", r, 32'h0);
    check("R7 irq released", {31'h0, cpu_irq}, 32'h0);

    // R6 bit 31 excluded in normal mode
    wr(3'd1, 32'h0);
    drive(32'h80000004);
    wr(3'd2, 32'hFFFFFFFF);
    rd(3'd0, r); check("R6 bit31 kept", r, 32'h80000000);
    // R8 immediate on mask write
    wr(3'd1, 32'h80000000);
    check("R8 irq on mask write edge", {31'h0, cpu_irq}, 32'h1);
    wr(3'd2, 32'h80000000);
    rd(3'd0, r); check("R7 clear-all clears bit31", r, 32'h0);
    check("R7 irq low after clear-all", {31'h0, cpu_irq}, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule